// File: doc/BRIEF.md
# Scrambled-Map Interrupt Controller

This block collects up to 64 level-sensitive interrupt sources and presents them to software through a small register file on a simple synchronous bus. Source numbers do not sit at the bit of the same index. Each source lands at a fixed but irregular word and bit position, spread over two 32-bit words: word 0, the "high" word, and word 1, the "low" word. The pending set and the enable (mask) set both use this layout.

Software enables sources by writing the two mask words. It clears captured requests by writing ones to the two pending words. It reads an identifier register that undoes the scrambled layout and names the lowest-numbered active source. A single registered request line tells the CPU that at least one enabled source is pending. A configuration word and two priority words are also kept, with fixed reset contents, so that software can store and read them back. They do not affect which source is selected.

Top module: `scram_irq_ctrl`

## Requirements
- R1: A source n that is high sets its pending bit at the following position (word 0 is the high word, word 1 the low word). For n from 1 to 15, word 1, bit 16-n. For n = 0, word 1, bit 0. For n = 16 and 17, word 0, bits 2 and 1. For n from 18 to 30, word 0, bit 33-n. For n = 31, word 0, bit 0. For n from 32 to 47, word 1, bit 63-n. For n from 48 to 63, word 0, bit n-32.
- R2: After reset, both mask words and both pending words read 0, the identifier reads 0 and `cpu_irq` is 0.
- R3: Writing a pending word clears each bit written with 1 and leaves each bit written with 0 unchanged.
- R4: A pending bit whose source is high is set in the next cycle, even if the same cycle's write cleared it.
- R5: The identifier register, at word address 4, reports in bits 31:26 the lowest nonzero source number that is both pending and enabled, or 0 when there is none.
- R6: Identifier bits 25:0 read 0, and reading any register leaves the pending words unchanged.
- R7: `cpu_irq` equals, one cycle later, the OR of pending AND mask over all 64 bit positions (source 0 included).
- R8: A mask bit of 1 enables its source and 0 blocks it from the identifier and from `cpu_irq`. A pending bit is still captured while its source is blocked.
- R9: Source 0 is never reported by the identifier. When it is the only enabled pending source, the identifier reads 0 while `cpu_irq` is 1.
- R10: The configuration word (address 5) resets to 0, and both priority words (addresses 6 and 7) reset to 0x05309770. All three hold and return what is written. The other addresses are: mask high 0, mask low 1, pending high 2, pending low 3.
- R11: Read data for an address presented in one cycle appears on `bus_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_level | input | 64 | Level request per source number |
| cpu_irq | output | 1 | Registered request to the CPU |

## Verification
The bench builds the block with its default address width of 4 and the default priority reset word, so every decoded address plus the unused addresses above 7 can be reached. A sweep of all 64 sources in turn covers the whole scrambled layout, including the irregular entries for sources 0, 16, 17 and 31. Directed cases cover selection order across both words, masking, the clear-while-high conflict, and the case where only source 0 is active.

// File: rtl/scirq_pkg.sv
package scirq_pkg;
  localparam int NSRC   = 64;
  localparam int WORD_W = 32;
  localparam int ID_W   = 6;
  localparam int ID_LSB = WORD_W - ID_W;

  // Flat position {word, bit}: word 0 = high word, word 1 = low word
  function automatic logic [ID_W-1:0] src_flat(input int n);
    int w;
    int b;
    if (n < 16) begin
      w = 1;
      b = (n == 0) ? 0 : 16 - n;
    end else if (n < 32) begin
      w = 0;
      if (n == 16)      b = 2;
      else if (n == 17) b = 1;
      else if (n == 31) b = 0;
      else              b = 33 - n;
    end else if (n < 48) begin
      w = 1;
      b = 63 - n;
    end else begin
      w = 0;
      b = n - 32;
    end
    return ID_W'(w * WORD_W + b);
  endfunction
endpackage

// File: rtl/scirq_src_map.sv
module scirq_src_map
  import scirq_pkg::*;
(
  input  logic [NSRC-1:0] src_level,
  output logic [NSRC-1:0] flat_level
);
  always_comb begin
    flat_level = '0;
    for (int n = 0; n < NSRC; n++) begin
      flat_level[src_flat(n)] = src_level[n];
    end
  end
endmodule

// File: rtl/scirq_pend_word.sv
module scirq_pend_word
  import scirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] lvl,
  input  logic [WORD_W-1:0] clr,
  output logic [WORD_W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | lvl;
  end

  // R4: a high level is captured in the next cycle
  p_level_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(lvl)) == $past(lvl)));
  // R3: bits not written with 1 stay set
  p_w1c_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr)));
  // R3: written ones with the level low clear the bit
  p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(clr & ~lvl)) == '0));
endmodule

// File: rtl/scirq_id_enc.sv
module scirq_id_enc
  import scirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] active,
  output logic [ID_W-1:0] src_id
);
  always_comb begin
    src_id = '0;
    for (int n = NSRC - 1; n >= 1; n--) begin
      if (active[src_flat(n)]) src_id = ID_W'(n);
    end
  end

  // R5: a reported source is really active
  p_id_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_id != '0) |-> active[src_flat(int'(src_id))]);
  // R9: nothing active except source 0 means no source is reported
  p_id_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((active & ~(NSRC'(1) << src_flat(0))) == '0) |-> (src_id == '0));
endmodule

// File: rtl/scram_irq_ctrl.sv
module scram_irq_ctrl
  import scirq_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] PRIO_RST = 32'h0530_9770
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_level,
  output logic              cpu_irq
);
  localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ID      = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CFG     = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_PRIO_HI = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_PRIO_LO = ADDR_W'(7);
  localparam int NWORD = NSRC / WORD_W;

  logic [NSRC-1:0]   flat_level;
  logic [NSRC-1:0]   pend_flat;
  logic [NSRC-1:0]   mask_flat;
  logic [NSRC-1:0]   active;
  logic [NSRC-1:0]   clr_flat;
  logic [ID_W-1:0]   src_id;
  logic [WORD_W-1:0] cfg_q, prio_hi_q, prio_lo_q;
  logic              any_active;

  scirq_src_map u_map (.src_level(src_level), .flat_level(flat_level));

  assign clr_flat[WORD_W-1:0]        = (bus_we && bus_addr == A_PEND_HI) ? bus_wdata : '0;
  assign clr_flat[2*WORD_W-1:WORD_W] = (bus_we && bus_addr == A_PEND_LO) ? bus_wdata : '0;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    scirq_pend_word u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (flat_level[w*WORD_W +: WORD_W]),
      .clr  (clr_flat[w*WORD_W +: WORD_W]),
      .pend (pend_flat[w*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_flat <= '0;
      cfg_q     <= '0;
      prio_hi_q <= PRIO_RST;
      prio_lo_q <= PRIO_RST;
    end else if (bus_we) begin
      case (bus_addr)
        A_MASK_HI: mask_flat[WORD_W-1:0]        <= bus_wdata;
        A_MASK_LO: mask_flat[2*WORD_W-1:WORD_W] <= bus_wdata;
        A_CFG:     cfg_q     <= bus_wdata;
        A_PRIO_HI: prio_hi_q <= bus_wdata;
        A_PRIO_LO: prio_lo_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign active     = pend_flat & mask_flat;
  assign any_active = |active;

  scirq_id_enc u_enc (.clk(clk), .rst_n(rst_n), .active(active), .src_id(src_id));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_irq   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      cpu_irq <= any_active;
      case (bus_addr)
        A_MASK_HI: bus_rdata <= mask_flat[WORD_W-1:0];
        A_MASK_LO: bus_rdata <= mask_flat[2*WORD_W-1:WORD_W];
        A_PEND_HI: bus_rdata <= pend_flat[WORD_W-1:0];
        A_PEND_LO: bus_rdata <= pend_flat[2*WORD_W-1:WORD_W];
        A_ID:      bus_rdata <= {src_id, {ID_LSB{1'b0}}};
        A_CFG:     bus_rdata <= cfg_q;
        A_PRIO_HI: bus_rdata <= prio_hi_q;
        A_PRIO_LO: bus_rdata <= prio_lo_q;
        default:   bus_rdata <= '0;
      endcase
    end
  end

  // R7: request line follows enabled pending state one cycle later
  p_irq_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(any_active)));
  // R6: identifier low bits read as zero
  p_id_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ID) |=> (bus_rdata[ID_LSB-1:0] == '0));
  // R8: no enabled pending source means no request
  p_mask_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_flat & mask_flat) == '0) |=> !cpu_irq);
endmodule

// File: tb/test_scram_irq_ctrl.sv
module test_scram_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_level = '0;
  logic        cpu_irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scram_irq_ctrl i_scram_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_level(src_level),
    .cpu_irq(cpu_irq)
  );

  // independent statement of the layout: returns {word, bit}
  function automatic int exp_word(input int n);
    if (n <= 15 || (n >= 32 && n <= 47)) return 1;
    return 0;
  endfunction
  function automatic int exp_bit(input int n);
    case (n)
      0: return 0;
      16: return 2;
      17: return 1;
      31: return 0;
      default: ;
    endcase
    if (n < 16) return 16 - n;
    if (n < 31) return 33 - n;
    if (n < 48) return 63 - n;
    return n - 32;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk); src_level = v;
  endtask

  task automatic clear_all();
    set_src('0);
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd0, d); check("R2 mask hi", d, 0);
    rd(4'd1, d); check("R2 mask lo", d, 0);
    rd(4'd2, d); check("R2 pend hi", d, 0);
    rd(4'd3, d); check("R2 pend lo", d, 0);
    rd(4'd4, d); check("R2 id", d, 0);
    check("R2 cpu_irq", cpu_irq, 0);
    rd(4'd5, d); check("R10 cfg reset", d, 0);
    rd(4'd6, d); check("R10 prio hi reset", d, 32'h0530_9770);
    rd(4'd7, d); check("R10 prio lo reset", d, 32'h0530_9770);
  endtask

  // R1 and R8: layout sweep with all sources masked
  task automatic t_layout();
    logic [31:0] hi, lo;
    logic [63:0] exp;
    for (int n = 0; n < 64; n++) begin
      set_src(64'd1 << n);
      rd(4'd2, hi);
      rd(4'd3, lo);
      exp = 64'd1 << (exp_word(n) * 32 + exp_bit(n));
      check($sformatf("R1 layout src %0d", n), {lo, hi}, exp);
      check("R8 masked no irq", cpu_irq, 0);
      clear_all();
    end
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);
    set_src((64'd1 << 5) | (64'd1 << 40) | (64'd1 << 20));
    rd(4'd4, d); check("R5 lowest of 5/20/40", d, 32'd5 << 26);
    check("R7 irq high", cpu_irq, 1);
    check("R6 low bits zero", {58'd0, d[25:0]}, 0);
    set_src((64'd1 << 40) | (64'd1 << 20));
    wr(4'd3, 32'd1 << exp_bit(5));
    rd(4'd4, d); check("R5 next is 20", d, 32'd20 << 26);
    set_src(64'd1 << 40);
    wr(4'd2, 32'd1 << exp_bit(20));
    rd(4'd4, d); check("R5 next is 40", d, 32'd40 << 26);
    set_src(64'd1 << 63);
    wr(4'd3, 32'd1 << exp_bit(40));
    rd(4'd4, d); check("R5 top source 63", d, 32'd63 << 26);
    clear_all();
    rd(4'd4, d); check("R5 none", d, 0);
    check("R7 irq low", cpu_irq, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(4'd0, 32'h0);
    wr(4'd1, 32'd1 << exp_bit(40));
    set_src((64'd1 << 5) | (64'd1 << 40));
    rd(4'd4, d); check("R8 only 40 enabled", d, 32'd40 << 26);
    wr(4'd1, 32'h0);
    rd(4'd4, d); check("R8 all blocked id", d, 0);
    check("R8 all blocked irq", cpu_irq, 0);
    rd(4'd3, d);
    check("R8 pend still captured", d, (32'd1 << exp_bit(5)) | (32'd1 << exp_bit(40)));
    clear_all();
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    set_src(64'd1 << 50);
    set_src('0);
    wr(4'd2, 32'h0);
    rd(4'd2, d); check("R3 zero write keeps", d, 32'd1 << 18);
    wr(4'd2, 32'd1 << 18);
    rd(4'd2, d); check("R3 one write clears", d, 0);
    set_src(64'd1 << 50);
    wr(4'd2, 32'd1 << 18);
    rd(4'd2, d); check("R4 level reasserts", d, 32'd1 << 18);
    rd(4'd2, d); check("R6 read no side effect", d, 32'd1 << 18);
    clear_all();
  endtask

  task automatic t_src0();
    logic [31:0] d;
    wr(4'd1, 32'd1 << exp_bit(0));
    set_src(64'd1);
    rd(4'd4, d); check("R9 src0 not reported", d, 0);
    check("R9 src0 raises irq", cpu_irq, 1);
    wr(4'd1, 32'h0);
    clear_all();
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(4'd5, 32'hA5A5_0F0F); rd(4'd5, d); check("R10 cfg write", d, 32'hA5A5_0F0F);
    wr(4'd6, 32'h1234_5678); rd(4'd6, d); check("R10 prio hi write", d, 32'h1234_5678);
    wr(4'd7, 32'h8765_4321); rd(4'd7, d); check("R10 prio lo write", d, 32'h8765_4321);
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, d); check("R5 id not writable", d, 0);
    // R11: data follows address by exactly one cycle
    @(negedge clk); bus_addr = 4'd5;
    @(negedge clk); bus_addr = 4'd6; check("R11 first read", bus_rdata, 32'hA5A5_0F0F);
    @(negedge clk); check("R11 second read", bus_rdata, 32'h1234_5678);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_priority();
    t_mask();
    t_w1c();
    t_src0();
    t_cfg();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule